// File: doc/BRIEF.md
# Two-Channel Multi-Standard CRC Signature Engine

This block accumulates a running CRC signature for each of two independent data streams. Every cycle in which a channel's valid strobe is high, one whole data word is folded into that channel's 64-bit signature register. The fold is an unrolled bit-serial loop, so the new signature appears after the next rising clock edge. Software configures each channel through one 32-bit control register. The settings per channel are the CRC standard, the word width, the order in which bits enter the CRC, and an optional byte reversal of the word.

A sticky clear bit per channel holds that channel's signature at zero for as long as the bit is set. Software must write the bit back to 0 before accumulation can resume. Each signature starts from zero and receives no final inversion. The result is right-aligned, and bits above the CRC width are always zero. The intended use is to stream a data set through a channel, then read back the signature and compare it with a precomputed value.

Top module: `crcsig_top`

## Requirements
- R1: The control register resets to 0. A write stores bits 15:0, and the read port returns the stored value. The reset value selects CRC-64, 64-bit words, MSB first and no byte swap on both channels.
- R2: Control bits 31:16 always read as zero, whatever value is written to them.
- R3: Each channel's 8-bit control field is bit 0 clear, bits 2:1 width, bits 4:3 type low, bit 5 bit order, bit 6 byte swap and bit 7 type high. Channel 0 uses bits 7:0 and channel 1 uses bits 15:8. The type code {bit7,bits4:3} selects the standard: 000 CRC-64 (poly 0x1B), 001 CRC-16 (0x1021), 010 CRC-32 (0x04C11DB7), 100 CRC-8 (0x1D), 101 CRC-8 (0x2F), 110 CRC-32C (0x1EDC6F41), and 011 or 111 E2E-4 CRC-32 (0xF4ACFB13).
- R4: Width code 01 takes data bits 15:0 and code 10 takes bits 31:0. Codes 00 and 11 take all 64 bits. Data bits above the selected width have no effect.
- R5: With bit order 0, the top bit of the word enters the CRC first. With bit order 1, bit 0 enters first.
- R6: When byte swap is 1, the byte order within the selected width is reversed, and this happens before the bit order is applied.
- R7: While a channel's clear bit is 1, its signature reads zero from the next edge on, even with valid high. The bit stays 1 until software writes 0.
- R8: A cycle with valid high folds exactly one word, and the result is visible after that edge. When valid is low and clear is 0, the signature holds its value.
- R9: The signature starts at zero and has no final XOR. It is right-aligned, and the bits above the CRC width are zero.
- R10: The two channels are independent: stimulus on one channel never changes the other channel's signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register contents |
| ch_valid | input | 2 | Per-channel word valid |
| ch_data | input | 128 | Channel n word at bits 64n+63:64n |
| ch_sig | output | 128 | Channel n signature at bits 64n+63:64n |

## Verification
The embedded assertions check four properties on every cycle. The reserved control bits stay zero. A set clear bit forces the signature to zero on the next edge. An idle channel holds its signature. After each fold, no bit above the active CRC width is set. The numeric correctness of each polynomial, the width selection, the bit order and the swap ordering can only be shown by the bench's scenarios. These compare single-word vectors with known results and compare multi-word streams with an independent bit-serial model. Channel independence and the persistence of the clear bit are also exercised only by the bench.

// File: rtl/crcsig_pkg.sv
package crcsig_pkg;
  localparam int SIG_W   = 64;
  localparam int FIELD_W = 8;
  localparam int CNT_W   = $clog2(SIG_W) + 1;

  typedef enum logic [2:0] {
    K_C64 = 3'b000, K_C16 = 3'b001, K_C32 = 3'b010, K_E2E_A = 3'b011,
    K_C8J = 3'b100, K_C8H = 3'b101, K_C32C = 3'b110, K_E2E_B = 3'b111
  } crc_kind_e;

  // Bit order of the packed struct matches the per-channel field layout.
  typedef struct packed {
    logic       kind_hi;
    logic       bswap;
    logic       lsb_first;
    logic [1:0] kind_lo;
    logic [1:0] width;
    logic       clr;
  } ch_cfg_t;

  function automatic logic [SIG_W-1:0] kind_poly(input crc_kind_e k);
    case (k)
      K_C64:   return 64'h0000_0000_0000_001B;
      K_C16:   return 64'h0000_0000_0000_1021;
      K_C32:   return 64'h0000_0000_04C1_1DB7;
      K_C8J:   return 64'h0000_0000_0000_001D;
      K_C8H:   return 64'h0000_0000_0000_002F;
      K_C32C:  return 64'h0000_0000_1EDC_6F41;
      default: return 64'h0000_0000_F4AC_FB13;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] kind_bits(input crc_kind_e k);
    case (k)
      K_C64:        return CNT_W'(64);
      K_C16:        return CNT_W'(16);
      K_C8J, K_C8H: return CNT_W'(8);
      default:      return CNT_W'(32);
    endcase
  endfunction

  // Feeds nb bits of w, top bit first, into a cb-bit CRC held in st.
  function automatic logic [SIG_W-1:0] fold_bits(
      input logic [SIG_W-1:0] st, input logic [SIG_W-1:0] w,
      input logic [CNT_W-1:0] nb, input logic [CNT_W-1:0] cb,
      input logic [SIG_W-1:0] poly);
    logic [SIG_W-1:0] s, msk;
    logic fb;
    msk = (int'(cb) >= SIG_W) ? '1 : ((SIG_W'(1) << cb) - SIG_W'(1));
    s = st;
    for (int i = 0; i < SIG_W; i++) begin
      if (i < int'(nb)) begin
        fb = s[int'(cb) - 1] ^ w[int'(nb) - 1 - i];
        s  = (s << 1) & msk;
        if (fb) s = s ^ poly;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/crcsig_cfg.sv
module crcsig_cfg #(
  parameter int NCH   = 2,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q
);
  import crcsig_pkg::*;
  localparam int USED_W = NCH * FIELD_W;
  localparam logic [CFG_W-1:0] USED_MASK = CFG_W'((64'd1 << USED_W) - 64'd1);

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= wdata & USED_MASK;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_q & ~USED_MASK) == '0);
endmodule

// File: rtl/crcsig_prep.sv
module crcsig_prep #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]             din,
  input  logic [1:0]                    width_sel,
  input  logic                          bswap,
  input  logic                          lsb_first,
  output logic [DATA_W-1:0]             word,
  output logic [crcsig_pkg::CNT_W-1:0]  nbits
);
  import crcsig_pkg::*;
  localparam int NVAR = 3;

  logic [DATA_W-1:0] cand [NVAR];

  // One swap/reorder network per supported width: 16, 32, 64 bits.
  for (genvar v = 0; v < NVAR; v++) begin : g_var
    localparam int VB = 16 << v;
    localparam int NB = VB / 8;
    logic [DATA_W-1:0] sw, ord;
    always_comb begin
      sw = '0;
      for (int k = 0; k < NB; k++)
        sw[8*k +: 8] = bswap ? din[8*(NB-1-k) +: 8] : din[8*k +: 8];
      ord = '0;
      for (int i = 0; i < VB; i++)
        ord[i] = lsb_first ? sw[VB-1-i] : sw[i];
    end
    assign cand[v] = ord;
  end

  always_comb begin
    case (width_sel)
      2'b01:   begin word = cand[0]; nbits = CNT_W'(16); end
      2'b10:   begin word = cand[1]; nbits = CNT_W'(32); end
      default: begin word = cand[2]; nbits = CNT_W'(64); end
    endcase
  end
endmodule

// File: rtl/crcsig_lane.sv
module crcsig_lane #(
  parameter int SIG_WIDTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         valid,
  input  logic [SIG_WIDTH-1:0]         word,
  input  logic [crcsig_pkg::CNT_W-1:0] nbits,
  input  crcsig_pkg::crc_kind_e        kind,
  output logic [SIG_WIDTH-1:0]         sig
);
  import crcsig_pkg::*;
  logic [SIG_WIDTH-1:0] nxt, msk;
  logic [CNT_W-1:0]     cbits;

  assign cbits = kind_bits(kind);
  assign msk   = (int'(cbits) >= SIG_WIDTH) ? '1 : ((SIG_WIDTH'(1) << cbits) - SIG_WIDTH'(1));
  assign nxt   = fold_bits(sig, word, nbits, cbits, kind_poly(kind));

  always_ff @(posedge clk) begin
    if (rst || clr) sig <= '0;
    else if (valid) sig <= nxt;
  end

  assert_sticky_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> sig == '0);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !valid) |=> $stable(sig));
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && !clr) |=> (sig & ~$past(msk)) == '0);
endmodule

// File: rtl/crcsig_top.sv
module crcsig_top #(
  parameter int NCH   = 2,
  parameter int SIG_W = 64,
  parameter int CFG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic [NCH-1:0]       ch_valid,
  input  logic [NCH*SIG_W-1:0] ch_data,
  output logic [NCH*SIG_W-1:0] ch_sig
);
  import crcsig_pkg::*;
  logic [CFG_W-1:0] cfg_q;

  crcsig_cfg #(.NCH(NCH), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg_q(cfg_q));
  assign cfg_rdata = cfg_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_cfg_t          f;
    logic [SIG_W-1:0] word;
    logic [CNT_W-1:0] nbits;
    crc_kind_e        kind;

    assign f    = ch_cfg_t'(cfg_q[FIELD_W*c +: FIELD_W]);
    assign kind = crc_kind_e'({f.kind_hi, f.kind_lo});

    crcsig_prep #(.DATA_W(SIG_W)) u_prep (
      .din(ch_data[SIG_W*c +: SIG_W]), .width_sel(f.width), .bswap(f.bswap),
      .lsb_first(f.lsb_first), .word(word), .nbits(nbits));

    crcsig_lane #(.SIG_WIDTH(SIG_W)) u_lane (
      .clk(clk), .rst(rst), .clr(f.clr), .valid(ch_valid[c]), .word(word),
      .nbits(nbits), .kind(kind), .sig(ch_sig[SIG_W*c +: SIG_W]));
  end
endmodule

// File: tb/test_crcsig_top.sv
module test_crcsig_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  // {cfg byte, data word, expected signature}; one word folded from zero.
  localparam logic [135:0] VEC [NVEC] = '{
    {8'h00, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_001B},
    {8'h0A, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_1021},
    {8'h14, 64'h0000_0000_0000_0001, 64'h0000_0000_04C1_1DB7},
    {8'h82, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_001D},
    {8'h8C, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_002F},
    {8'h90, 64'h0000_0000_0000_0001, 64'h0000_0000_1EDC_6F41},
    {8'h1A, 64'h0000_0000_0000_0001, 64'h0000_0000_F4AC_FB13},
    {8'h9C, 64'h0000_0000_0000_0001, 64'h0000_0000_F4AC_FB13},
    {8'h2A, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_1021},
    {8'h4A, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_1021},
    {8'h54, 64'h0000_0000_0100_0000, 64'h0000_0000_04C1_1DB7},
    {8'h82, 64'hFFFF_FFFF_FFFF_0001, 64'h0000_0000_0000_001D},
    {8'h74, 64'h0000_0000_0000_0080, 64'h0000_0000_04C1_1DB7},
    {8'h40, 64'h0100_0000_0000_0000, 64'h0000_0000_0000_001B},
    {8'h06, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_001B}
  };

  logic clk = 0, rst = 1, cfg_we = 0;
  logic [31:0]  cfg_wdata = '0, cfg_rdata;
  logic [1:0]   ch_valid = '0;
  logic [127:0] ch_data = '0, ch_sig;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crcsig_top i_crcsig_top (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ch_valid(ch_valid), .ch_data(ch_data), .ch_sig(ch_sig));

  function automatic logic [63:0] ref_fold(logic [63:0] st, logic [63:0] d, logic [7:0] c);
    int wb, nb, cw; logic [63:0] w, poly, msk; logic b, top;
    wb = (c[2:1] == 2'b01) ? 16 : (c[2:1] == 2'b10) ? 32 : 64;
    nb = wb / 8;
    case ({c[7], c[4:3]})
      3'b000: begin poly = 64'h1B;        cw = 64; end
      3'b001: begin poly = 64'h1021;      cw = 16; end
      3'b010: begin poly = 64'h04C11DB7;  cw = 32; end
      3'b100: begin poly = 64'h1D;        cw = 8;  end
      3'b101: begin poly = 64'h2F;        cw = 8;  end
      3'b110: begin poly = 64'h1EDC6F41;  cw = 32; end
      default: begin poly = 64'hF4ACFB13; cw = 32; end
    endcase
    msk = (cw == 64) ? '1 : ((64'd1 << cw) - 64'd1);
    w = '0;
    for (int k = 0; k < nb; k++) w[8*k +: 8] = c[6] ? d[8*(nb-1-k) +: 8] : d[8*k +: 8];
    for (int i = 0; i < wb; i++) begin
      b = c[5] ? w[i] : w[wb-1-i];
      top = st[cw-1];
      st = (st << 1) & msk;
      if (top ^ b) st = st ^ poly;
    end
    return st;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(logic [1:0] vld, logic [63:0] d0, logic [63:0] d1);
    ch_valid = vld; ch_data = {d1, d0};
    @(negedge clk);
    ch_valid = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] r0, r1, held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset cfg", 64'(cfg_rdata), 64'h0);
    chk("R1 reset sig0", ch_sig[63:0], 64'h0);
    chk("R1 reset sig1", ch_sig[127:64], 64'h0);
    // R2: reserved bits
    wr(32'hFFFF_FFFF);
    chk("R2 reserved", 64'(cfg_rdata), 64'h0000_FFFF);
    wr(32'h0000_0000);

    // Table walk (R3, R4, R5, R6, R9): both channels, fresh signature each time.
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c; logic [63:0] d, e;
      {c, d, e} = VEC[v];
      wr({16'h0, c | 8'h01, c | 8'h01});
      wr({16'h0, c, c});
      chk("R1 readback", 64'(cfg_rdata), {48'h0, c, c});
      push(2'b11, d, d);
      chk("R3 R4 R5 R6 R9 table ch0", ch_sig[63:0], e);
      chk("R3 R4 R5 R6 R9 table ch1", ch_sig[127:64], e);
    end

    // Multi-word streams against the serial model, every mode.
    for (int t = 0; t < 8; t++) begin
      for (int w = 1; w < 4; w++) begin
        for (int o = 0; o < 4; o++) begin
          logic [7:0] c;
          c = {t[2], o[1], o[0], t[1:0], w[1:0], 1'b0};
          wr({16'h0, c | 8'h01, c | 8'h01});
          wr({16'h0, c, c});
          r0 = '0; r1 = '0;
          for (int n = 0; n < 4; n++) begin
            logic [63:0] d0, d1;
            d0 = {$urandom, $urandom}; d1 = {$urandom, $urandom};
            push(2'b11, d0, d1);
            r0 = ref_fold(r0, d0, c); r1 = ref_fold(r1, d1, c);
            chk("R8 R3 stream ch0", ch_sig[63:0], r0);
            chk("R8 R4 stream ch1", ch_sig[127:64], r1);
          end
        end
      end
    end

    // R8: idle holds.
    held = ch_sig[63:0];
    repeat (3) @(negedge clk);
    chk("R8 idle hold", ch_sig[63:0], held);

    // R7 and R10: clear on channel 0 is sticky while channel 1 streams.
    wr(32'h0000_0001);
    r1 = '0;
    wr(32'h0000_0101);
    wr(32'h0000_0001);
    for (int n = 0; n < 3; n++) begin
      push(2'b11, 64'hDEAD_BEEF_0BAD_F00D + 64'(n), 64'h1234_5678_9ABC_DEF0 + 64'(n));
      r1 = ref_fold(r1, 64'h1234_5678_9ABC_DEF0 + 64'(n), 8'h00);
      chk("R7 held zero", ch_sig[63:0], 64'h0);
      chk("R10 other channel runs", ch_sig[127:64], r1);
    end
    chk("R7 bit stays set", 64'(cfg_rdata), 64'h1);
    wr(32'h0000_0000);
    push(2'b01, 64'h1, 64'h0);
    chk("R7 resumes after release", ch_sig[63:0], 64'h1B);
    chk("R10 idle channel unchanged", ch_sig[127:64], r1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule